// File: doc/BRIEF.md
# Accumulator Add/Subtract Unit with Flags

This block performs the four carry-aware arithmetic operations of a small 8-bit processor core: plain add, add with carry, plain subtract and subtract with borrow. The accumulator value and a second operand come in together with the carry bit from the flag register. The block returns the 8-bit result and a flag byte that holds zero, subtract, half-carry and carry indications in its upper nibble.

The arithmetic is purely combinational. A register stage at the top latches the result and flag byte on any clock edge where the enable pin is high, so the value can be observed one cycle after it is presented. The incoming carry is kept as a separate one-bit term of a 9-bit sum and is never merged into the second operand first. This keeps the carry and half-carry correct when the second operand is 0xFF and the carry is set. Both flags are recovered by comparing the true sum against the carry-free bitwise sum.

The block has no handshake at its edge. Its pins are plain control and data. The enable pin gives the only flow control: while it is low the outputs hold, and no input is taken.

Top module: `acc_arith_unit`

## Requirements
- R1: With op = 0 (plain add), the registered result equals (opa + opb) mod 256 and flags bit 6 (subtract) is 0.
- R2: With op = 1 (add with carry), the result equals (opa + opb + cin) mod 256. When opb = 0xFF and cin = 1, the result equals opa and both flags bit 4 and flags bit 5 are 1.
- R3: For the add operations, flags bit 5 (half-carry) is 1 exactly when the low nibbles of opa and opb, plus the carry term when op = 1, add up to more than 15.
- R4: For the add operations, flags bit 4 (carry) is 1 exactly when the full sum exceeds 255.
- R5: With op = 2 (plain subtract), the result equals (opa - opb) mod 256 and flags bit 6 is 1. Flags bit 4 is 1 when opa < opb. Flags bit 5 is 1 when the low nibble of opa is less than the low nibble of opb.
- R6: With op = 3 (subtract with borrow), the result equals (opa - opb - cin) mod 256 and flags bit 6 is 1. Bits 4 and 5 report borrow from the full byte and from the low nibble, with cin counted in. When opb = 0xFF and cin = 1, the result equals opa and both bits are 1.
- R7: Flags bit 7 (zero) is 1 exactly when the 8-bit result is 0x00.
- R8: Flags bits 3..0 are always 0.
- R9: For op = 0 and op = 2, the value of cin has no effect on the result or the flags.
- R10: The result and flags update one clock after a rising edge with en = 1. While en = 0 they hold their value, whatever the other inputs do.
- R11: While rst_n is low, result and flags are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Latch enable for the output register |
| op | input | 2 | 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow |
| opa | input | 8 | Accumulator operand |
| opb | input | 8 | Second operand |
| cin | input | 1 | Carry or borrow from the flag register |
| result | output | 8 | Registered arithmetic result |
| flags | output | 8 | Registered flags: bit 7 zero, bit 6 subtract, bit 5 half-carry, bit 4 carry, bits 3..0 zero |

## Verification
The case that is hardest to reach is a carry-in arriving on top of an all-ones second operand. If the carry were folded into the operand, the operand would wrap to zero and both carry flags would be lost. Random stimulus seldom lands on this case, and it looks correct for almost every accumulator value. The stimulus therefore runs the add-with-carry operation over every operand pair with the carry set. It also sweeps every accumulator value for all four operations and both carry values, against a set of nibble-boundary second operands that includes 0xFF. It adds directed checks with hand-worked flag bytes for the known wrap cases of both add and subtract.

// File: rtl/acc_arith_pkg.sv
package acc_arith_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_ADC = 2'd1,
    OP_SUB = 2'd2,
    OP_SBC = 2'd3
  } arith_op_e;

  localparam int FLAG_W   = 8;
  localparam int FLG_ZERO = 7;
  localparam int FLG_SUBT = 6;
  localparam int FLG_HALF = 5;
  localparam int FLG_CARY = 4;

endpackage

// File: rtl/acc_arith_sum.sv
module acc_arith_sum #(
  parameter int DATA_W = 8,
  parameter int HALF_POS = 4
) (
  input  logic              is_sub,
  input  logic              use_cin,
  input  logic              cin,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              half_out,
  output logic              full_out
);
  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] ext_a;
  logic [EXT_W-1:0] ext_b;
  logic [EXT_W-1:0] cin_term;
  logic [EXT_W-1:0] total;
  logic [EXT_W-1:0] nocarry;
  logic [EXT_W-1:0] carry_into;

  always_comb begin
    ext_a    = {1'b0, a};
    ext_b    = {1'b0, b};
    // carry kept as its own term, never folded into b
    cin_term = {{DATA_W{1'b0}}, use_cin & cin};
    if (is_sub) begin
      total = ext_a - ext_b - cin_term;
    end else begin
      total = ext_a + ext_b + cin_term;
    end
    nocarry    = ext_a ^ ext_b;
    carry_into = total ^ nocarry;
  end

  assign res      = total[DATA_W-1:0];
  assign half_out = carry_into[HALF_POS];
  assign full_out = carry_into[DATA_W];

endmodule

// File: rtl/acc_arith_flags.sv
module acc_arith_flags
  import acc_arith_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] res,
  input  logic              is_sub,
  input  logic              half_in,
  input  logic              full_in,
  output logic [FLAG_W-1:0] flags
);
  always_comb begin
    flags           = '0;
    flags[FLG_ZERO] = (res == '0);
    flags[FLG_SUBT] = is_sub;
    flags[FLG_HALF] = half_in;
    flags[FLG_CARY] = full_in;
  end
endmodule

// File: rtl/acc_arith_reg.sv
module acc_arith_reg #(
  parameter int DATA_W = 8,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] d_res,
  input  logic [FLAG_W-1:0] d_flags,
  output logic [DATA_W-1:0] q_res,
  output logic [FLAG_W-1:0] q_flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_res   <= '0;
      q_flags <= '0;
    end else if (en) begin
      q_res   <= d_res;
      q_flags <= d_flags;
    end
  end
endmodule

// File: rtl/acc_arith_unit.sv
module acc_arith_unit
  import acc_arith_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HALF_POS = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              cin,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        flags
);
  arith_op_e         op_e;
  logic              is_sub;
  logic              use_cin;
  logic [DATA_W-1:0] comb_res;
  logic              half_c;
  logic              full_c;
  logic [FLAG_W-1:0] comb_flags;

  assign op_e    = arith_op_e'(op);
  assign is_sub  = (op_e == OP_SUB) || (op_e == OP_SBC);
  assign use_cin = (op_e == OP_ADC) || (op_e == OP_SBC);

  acc_arith_sum #(.DATA_W(DATA_W), .HALF_POS(HALF_POS)) u_sum (
    .is_sub   (is_sub),
    .use_cin  (use_cin),
    .cin      (cin),
    .a        (opa),
    .b        (opb),
    .res      (comb_res),
    .half_out (half_c),
    .full_out (full_c)
  );

  acc_arith_flags #(.DATA_W(DATA_W)) u_flags (
    .res     (comb_res),
    .is_sub  (is_sub),
    .half_in (half_c),
    .full_in (full_c),
    .flags   (comb_flags)
  );

  acc_arith_reg #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .d_res   (comb_res),
    .d_flags (comb_flags),
    .q_res   (result),
    .q_flags (flags)
  );

endmodule

// File: rtl/acc_arith_unit_chk.sv
module acc_arith_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [1:0] op,
  input logic [7:0] opa,
  input logic [7:0] opb,
  input logic       cin,
  input logic [7:0] result,
  input logic [7:0] flags
);

  a_r8_low_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flags[3:0] == 4'h0);

  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(result) && $stable(flags)));

  a_r1_add_clears_subt: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !op[1]) |=> !flags[6]);

  a_r5_sub_sets_subt: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op[1]) |=> flags[6]);

  a_r7_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (flags[7] == (result == 8'h00)));

  a_r9_add_ignores_cin: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 2'd0) |=> (result == 8'($past(opa) + $past(opb))));

  a_r2_ff_with_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 2'd1 && cin && opb == 8'hFF) |=>
      (flags[4] && flags[5] && result == $past(opa)));

  a_r6_ff_with_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 2'd3 && cin && opb == 8'hFF) |=>
      (flags[4] && flags[5] && result == $past(opa)));

endmodule

bind acc_arith_unit acc_arith_unit_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (en),
  .op     (op),
  .opa    (opa),
  .opb    (opb),
  .cin    (cin),
  .result (result),
  .flags  (flags)
);

// File: tb/acc_arith_unit_bench.sv
module acc_arith_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] op = 2'd0;
  logic [7:0] opa = 8'h00;
  logic [7:0] opb = 8'h00;
  logic       cin = 1'b0;
  logic [7:0] result;
  logic [7:0] flags;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic       pend = 1'b0;
  logic [7:0] pend_res;
  logic [7:0] pend_flg;
  string      pend_tag;

  always #(CLK_PERIOD / 2) clk = ~clk;

  acc_arith_unit u_acc_arith_unit (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .opa(opa), .opb(opb),
    .cin(cin), .result(result), .flags(flags)
  );

  // Reference model written from the requirements: returns {result, flags}
  function automatic logic [15:0] model(input logic [1:0] o, input logic [7:0] a,
                                        input logic [7:0] b, input logic c);
    int s, lo, uc;
    logic h, cy, n;
    logic [7:0] r;
    uc = o[0] ? int'(c) : 0;
    if (!o[1]) begin
      s  = int'(a) + int'(b) + uc;
      lo = int'(a & 8'h0F) + int'(b & 8'h0F) + uc;
      h  = lo > 15;
      cy = s > 255;
      n  = 1'b0;
    end else begin
      s  = int'(a) - int'(b) - uc;
      lo = int'(a & 8'h0F) - int'(b & 8'h0F) - uc;
      h  = lo < 0;
      cy = s < 0;
      n  = 1'b1;
    end
    r = 8'(s & 255);
    return {r, (r == 8'h00), n, h, cy, 4'h0};
  endfunction

  task automatic check_pending();
    if (pend) begin
      checks++;
      if (result !== pend_res || flags !== pend_flg) begin
        failures++;
        $display("FAIL %s: actual result=%02h flags=%02h expected result=%02h flags=%02h",
                 pend_tag, result, flags, pend_res, pend_flg);
      end
      pend = 1'b0;
    end
  endtask

  // one vector per cycle: check the previous vector, then drive the next
  task automatic step(input logic [1:0] o, input logic [7:0] a, input logic [7:0] b,
                      input logic c, input logic [7:0] er, input logic [7:0] ef,
                      input string tag);
    @(negedge clk);
    check_pending();
    en = 1'b1; op = o; opa = a; opb = b; cin = c;
    pend = 1'b1; pend_res = er; pend_flg = ef; pend_tag = tag;
  endtask

  task automatic step_model(input logic [1:0] o, input logic [7:0] a,
                            input logic [7:0] b, input logic c);
    logic [15:0] e;
    string tag;
    e = model(o, a, b, c);
    case (o)
      2'd0: tag = "R1/R3/R4/R7 add";
      2'd1: tag = "R2/R3/R4/R7 add-carry";
      2'd2: tag = "R5/R7 sub";
      default: tag = "R6/R7 sub-borrow";
    endcase
    step(o, a, b, c, e[15:8], e[7:0], tag);
  endtask

  task automatic flush();
    @(negedge clk);
    check_pending();
    en = 1'b0;
  endtask

  task automatic check_now(input logic [7:0] er, input logic [7:0] ef, input string tag);
    checks++;
    if (result !== er || flags !== ef) begin
      failures++;
      $display("FAIL %s: actual result=%02h flags=%02h expected result=%02h flags=%02h",
               tag, result, flags, er, ef);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_now(8'h00, 8'h00, "R11 reset state");
    rst_n = 1'b1;
  endtask

  task automatic t_known_wraps();
    step(2'd1, 8'h01, 8'hFE, 1'b1, 8'h00, 8'hB0, "R2/R7 add-carry wrap to zero");
    step(2'd1, 8'h01, 8'hFE, 1'b0, 8'hFF, 8'h00, "R2 add-carry no carry");
    step(2'd1, 8'h37, 8'hFF, 1'b1, 8'h37, 8'h30, "R2 opb FF with carry");
    step(2'd3, 8'h37, 8'hFF, 1'b1, 8'h37, 8'h70, "R6 opb FF with borrow");
    step(2'd0, 8'h0F, 8'h01, 1'b0, 8'h10, 8'h20, "R3 nibble carry");
    step(2'd0, 8'h80, 8'h80, 1'b0, 8'h00, 8'h90, "R4/R7 byte carry to zero");
    step(2'd2, 8'h10, 8'h01, 1'b0, 8'h0F, 8'h60, "R5 nibble borrow");
    step(2'd2, 8'h42, 8'h42, 1'b0, 8'h00, 8'hC0, "R5/R7 equal operands");
    flush();
  endtask

  task automatic t_cin_ignored();
    step(2'd0, 8'h10, 8'h20, 1'b1, 8'h30, 8'h00, "R9 add ignores cin");
    step(2'd0, 8'hFF, 8'h01, 1'b1, 8'h00, 8'hB0, "R9 add ignores cin at wrap");
    step(2'd2, 8'h10, 8'h20, 1'b1, 8'hF0, 8'h50, "R9 sub ignores cin");
    step(2'd2, 8'h05, 8'h05, 1'b1, 8'h00, 8'hC0, "R9 sub ignores cin at zero");
    flush();
  endtask

  task automatic t_hold();
    step(2'd0, 8'h12, 8'h34, 1'b0, 8'h46, 8'h00, "R10 load before hold");
    flush();
    op = 2'd3; opa = 8'h00; opb = 8'hFF; cin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_now(8'h46, 8'h00, "R10 hold while en low");
  endtask

  task automatic t_boundary_sweep();
    logic [7:0] bset [9] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hF0, 8'hFE, 8'hFF};
    for (int o = 0; o < 4; o++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 256; a++)
          for (int k = 0; k < 9; k++)
            step_model(2'(o), 8'(a), bset[k], 1'(c));
    flush();
  endtask

  task automatic t_adc_exhaustive();
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        step_model(2'd1, 8'(a), 8'(b), 1'b1);
    flush();
  endtask

  task automatic t_mid_reset();
    step(2'd0, 8'h55, 8'h11, 1'b0, 8'h66, 8'h00, "R1 load before reset");
    flush();
    rst_n = 1'b0;
    @(negedge clk);
    check_now(8'h00, 8'h00, "R11 reset mid-run");
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_known_wraps();
    t_cin_ignored();
    t_hold();
    t_boundary_sweep();
    t_adc_exhaustive();
    t_mid_reset();
    finished = 1'b1;
    finish_run();
  end

endmodule